// File: doc/BRIEF.md
# Two-Bank Hashed Recent-Line Filter

This block remembers which cache lines completed recently so that an offset-learning engine can ask "was line X seen lately?" with one lookup. It holds two direct-mapped banks of partial tags. The left bank takes its entries from the demand side, one base line address per write. The right bank takes its entries from completed prefetch fills. Each bank has its own write port, so the two banks are updated by separate events and never both at once from a single access.

Both banks are indexed by an XOR-fold of the line address. The fold's shift distance is the index width scaled by the bank number: one index width for the left bank and two for the right bank. Because the shift differs, one line lands in different slots in the two banks. Each slot keeps only the low tag bits of the line, so lines that share those bits and the slot alias. A query probes both banks in parallel. One clock later it reports a single hit flag.

Top module: `rrt_table`

## Requirements
- R1: While rst_ni is low, hit_o is 0 and every slot of both banks becomes invalid, so after reset no query hits until a new write.
- R2: hit_o is registered: it reflects the query presented in the previous cycle, and it is 0 in any cycle whose previous cycle had query_vld_i low.
- R3: A demand write places its line in the left bank at slot (line ^ (line >> LOG_ENTRIES)) masked to LOG_ENTRIES bits.
- R4: A fill write places its line in the right bank at slot (line ^ (line >> 2*LOG_ENTRIES)) masked to LOG_ENTRIES bits, so a line differing only in bits at or above 2*LOG_ENTRIES probes a different right slot.
- R5: A slot stores only line[TAG_BITS-1:0]. A query with equal low tag bits that maps to the same slot hits even when its higher bits differ.
- R6: A query hits when either bank has a valid slot at that bank's index for the query line whose stored tag equals the query tag.
- R7: A write overwrites its slot unconditionally and marks it valid. A line displaced this way no longer hits.
- R8: When a query and a write fall in the same cycle, the query sees the contents from before that write.
- R9: Demand writes touch only the left bank and fill writes only the right bank. Both may occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dmd_vld_i | input | 1 | Write the left bank |
| dmd_line_i | input | LINE_W | Line address for the left-bank write |
| fill_vld_i | input | 1 | Write the right bank |
| fill_line_i | input | LINE_W | Line address for the right-bank write |
| qry_vld_i | input | 1 | Query request |
| qry_line_i | input | LINE_W | Line address to query |
| hit_o | output | 1 | Query result, one cycle after the query |

## Verification
The bench places a query in the same cycle as a write to the queried slot. A design that forwarded the new data would report the hit one cycle early. It probes a line that differs from a filled line only in bits 12 and up. If the right bank used the left bank's shift, that probe would wrongly hit. It probes, at the left slot, a line that was written only to the right bank, which exposes a fill port that also writes the left bank. It checks that an overwritten line stops hitting and that a partial-tag alias does hit. It also checks that reset in the middle of a run leaves no stale hits.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int unsigned LINE_W_DEF  = 26;
  localparam int unsigned LOG_ENT_DEF = 6;
  localparam int unsigned TAG_W_DEF   = 12;

  typedef enum int unsigned {
    BANK_LEFT  = 0,
    BANK_RIGHT = 1
  } bank_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/rrt_hash.sv
module rrt_hash #(
  parameter int unsigned LINE_W  = rrt_pkg::LINE_W_DEF,
  parameter int unsigned LOG_ENT = rrt_pkg::LOG_ENT_DEF,
  parameter int unsigned BANK    = 0
) (
  input  logic [LINE_W-1:0]  line_i,
  output logic [LOG_ENT-1:0] idx_o
);
  localparam int unsigned SHIFT = LOG_ENT << BANK;

  logic [LINE_W-1:0] mix;

  always_comb begin
    mix   = line_i ^ (line_i >> SHIFT);
    idx_o = mix[LOG_ENT-1:0];
  end
endmodule

// File: rtl/rrt_bank.sv
module rrt_bank #(
  parameter int unsigned LINE_W  = rrt_pkg::LINE_W_DEF,
  parameter int unsigned LOG_ENT = rrt_pkg::LOG_ENT_DEF,
  parameter int unsigned TAG_W   = rrt_pkg::TAG_W_DEF,
  parameter int unsigned BANK    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [LINE_W-1:0] rd_line_i,
  output logic              rd_hit_o
);
  localparam int unsigned ENTRIES = 1 << LOG_ENT;

  logic [LOG_ENT-1:0]             wr_idx, rd_idx;
  logic [TAG_W-1:0]               wr_tag, rd_tag;
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;

  rrt_hash #(.LINE_W(LINE_W), .LOG_ENT(LOG_ENT), .BANK(BANK)) u_wr_hash (
    .line_i(wr_line_i),
    .idx_o (wr_idx)
  );

  rrt_hash #(.LINE_W(LINE_W), .LOG_ENT(LOG_ENT), .BANK(BANK)) u_rd_hash (
    .line_i(rd_line_i),
    .idx_o (rd_idx)
  );

  assign wr_tag = wr_line_i[TAG_W-1:0];
  assign rd_tag = rd_line_i[TAG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (wr_vld_i) begin
      valid_q[wr_idx] <= 1'b1;
      tag_q[wr_idx]   <= wr_tag;
    end
  end

  // read before write: same-cycle write is not forwarded
  assign rd_hit_o = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

  // R7
  wr_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_i |=> valid_q[$past(wr_idx)]);

  // R5
  wr_tag_stored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_i |=> tag_q[$past(wr_idx)] == $past(wr_line_i[TAG_W-1:0]));

  // R9
  idle_bank_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_vld_i |=> ($stable(valid_q) && $stable(tag_q)));
endmodule

// File: rtl/rrt_table.sv
module rrt_table #(
  parameter int unsigned LINE_W  = rrt_pkg::LINE_W_DEF,
  parameter int unsigned LOG_ENT = rrt_pkg::LOG_ENT_DEF,
  parameter int unsigned TAG_W   = rrt_pkg::TAG_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dmd_vld_i,
  input  logic [LINE_W-1:0] dmd_line_i,
  input  logic              fill_vld_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              qry_vld_i,
  input  logic [LINE_W-1:0] qry_line_i,
  output logic              hit_o
);
  import rrt_pkg::*;

  logic [NUM_BANKS-1:0]             bank_wr_vld;
  logic [NUM_BANKS-1:0][LINE_W-1:0] bank_wr_line;
  logic [NUM_BANKS-1:0]             bank_hit;
  logic                             hit_q;

  assign bank_wr_vld[BANK_LEFT]   = dmd_vld_i;
  assign bank_wr_line[BANK_LEFT]  = dmd_line_i;
  assign bank_wr_vld[BANK_RIGHT]  = fill_vld_i;
  assign bank_wr_line[BANK_RIGHT] = fill_line_i;

  for (genvar w = 0; w < NUM_BANKS; w++) begin : g_bank
    rrt_bank #(
      .LINE_W (LINE_W),
      .LOG_ENT(LOG_ENT),
      .TAG_W  (TAG_W),
      .BANK   (w)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_vld_i (bank_wr_vld[w]),
      .wr_line_i(bank_wr_line[w]),
      .rd_line_i(qry_line_i),
      .rd_hit_o (bank_hit[w])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= qry_vld_i && (|bank_hit);
  end

  assign hit_o = hit_q;

  // R2
  no_idle_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qry_vld_i |=> !hit_o);

  // R6
  miss_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_vld_i && bank_hit == '0) |=> !hit_o);
endmodule

// File: tb/sim_rrt_table.sv
module sim_rrt_table;
  localparam int unsigned LW = 26;

  typedef struct packed {
    logic          dv;
    logic [LW-1:0] da;
    logic          fv;
    logic [LW-1:0] fa;
    logic          qv;
    logic [LW-1:0] qa;
    logic          exp_hit;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h41,   1'b0}, // 0  R6 empty
    '{1'b1, 26'h41,   1'b0, 26'h0,    1'b1, 26'h41,   1'b0}, // 1  R8 old data
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h41,   1'b1}, // 2  R3
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h1041, 1'b1}, // 3  R5 alias
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h81,   1'b0}, // 4  R6 miss
    '{1'b0, 26'h0,    1'b1, 26'h81,   1'b0, 26'h81,   1'b0}, // 5  R2 no query
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h81,   1'b1}, // 6  R4
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h41,   1'b1}, // 7  R6
    '{1'b1, 26'h2082, 1'b0, 26'h0,    1'b1, 26'h41,   1'b1}, // 8  R8
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h41,   1'b0}, // 9  R7 evicted
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h2082, 1'b1}, // 10 R7
    '{1'b0, 26'h0,    1'b1, 26'h7,    1'b0, 26'h0,    1'b0}, // 11 R2
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h7,    1'b1}, // 12 R4
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h1007, 1'b0}, // 13 R4 shift
    '{1'b0, 26'h0,    1'b1, 26'h100B, 1'b0, 26'h0,    1'b0}, // 14 R2
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h200B, 1'b0}, // 15 R9
    '{1'b1, 26'h10,   1'b1, 26'h20,   1'b0, 26'h0,    1'b0}, // 16 R9
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h10,   1'b1}, // 17 R9
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h20,   1'b1}, // 18 R9
    '{1'b0, 26'h0,    1'b0, 26'h0,    1'b1, 26'h1020, 1'b0}  // 19 R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dv = 1'b0, fv = 1'b0, qv = 1'b0;
  logic [LW-1:0] da = '0, fa = '0, qa = '0;
  logic          hit;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  rrt_table u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .dmd_vld_i(dv), .dmd_line_i(da),
    .fill_vld_i(fv), .fill_line_i(fa),
    .qry_vld_i(qv), .qry_line_i(qa),
    .hit_o(hit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s hit_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic [LW-1:0] a_d,
                      input logic f, input logic [LW-1:0] a_f,
                      input logic q, input logic [LW-1:0] a_q);
    @(negedge clk);
    dv = d; da = a_d; fv = f; fa = a_f; qv = q; qa = a_q;
    @(posedge clk);
    #1;
    dv = 1'b0; fv = 1'b0; qv = 1'b0;
  endtask

  initial begin
    #3;
    check("R1", hit, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].dv, VEC[i].da, VEC[i].fv, VEC[i].fa, VEC[i].qv, VEC[i].qa);
      check($sformatf("R2/R3-R9 vec%0d", i), hit, VEC[i].exp_hit);
    end

    // R1: reset mid-run wipes both banks
    @(negedge clk);
    qv = 1'b1; qa = 26'h2082;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 during reset", hit, 1'b0);
    @(negedge clk);
    qv = 1'b0;
    rst_n = 1'b1;
    step(1'b0, '0, 1'b0, '0, 1'b1, 26'h2082);
    check("R1 left cleared", hit, 1'b0);
    step(1'b0, '0, 1'b0, '0, 1'b1, 26'h7);
    check("R1 right cleared", hit, 1'b0);
    // R7 re-write after reset
    step(1'b0, '0, 1'b1, 26'h7, 1'b0, '0);
    step(1'b0, '0, 1'b0, '0, 1'b1, 26'h7);
    check("R7 rewrite", hit, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule